// File: doc/BRIEF.md
# Multi-Channel Circular Command Queue with Debug Peek

The block keeps one command queue per channel inside a shared word RAM. Each channel owns a slice of the RAM, bounded by a programmable lower address (base) and upper address (limit). Its read and write pointers step upward through that slice and jump from the limit back to the base. Producers push words into a channel, and consumers pop them in arrival order. Per-channel empty and full flags show the state of every queue.

A debug peek port lets a host look inside the queues without disturbing them. The host writes a peek control word that holds an enable, a channel number and a RAM address. While peeking is enabled, the block shows the selected channel's two pointers and returns the RAM word at the peek address. Pushes use the RAM write port. Pops and peeks share the RAM read port, and a pop always wins that port.

Top module: `cfq_cmd_fifo`

## Requirements
- R1: After reset every channel reports empty=1 and full=0. pop_dvalid and peek_valid are 0, and both peek pointer outputs are 0. Channel i starts with base i*(DEPTH/NCH) and limit base+DEPTH/NCH-1.
- R2: A push is accepted (push_ack=1 in the same cycle) when push_req is high and the channel is not full. The word is stored at the write pointer, and pops return words in the order they were pushed.
- R3: When a pointer that advances equals the channel limit, its next value is the channel base. Otherwise it increments by one.
- R4: A channel is empty when its read pointer equals its write pointer. A pop request to an empty channel gets pop_ack=0 and moves no pointer.
- R5: A channel is full when advancing its write pointer would make it equal its read pointer, so it holds limit-base words. A push to a full channel gets push_ack=0 and the word is dropped.
- R6: The word for an accepted pop appears on pop_data with pop_dvalid=1 in the cycle after pop_ack. pop_dvalid and peek_valid are never high together.
- R7: A setup write (cfg_we) loads the base and limit of cfg_ch and sets both of its pointers to the new base. A push or pop to that same channel in the same cycle is refused.
- R8: A peek control write stores the enable, the channel and the address. While enabled, peek_rd_ptr and peek_wr_ptr show the selected channel's pointers. A write with enable 0 turns peeking off, and the pointer outputs then read 0.
- R9: In every cycle where peeking is enabled, no pop is accepted and no peek control write occurs, the RAM word at the peek address is read. In the next cycle it appears on peek_data with peek_valid=1.
- R10: In a cycle with an accepted pop, the peek read is skipped and peek_valid is 0 in the next cycle. Peeking never changes any pointer.
- R11: Pushes and pops to one channel leave the pointers and contents of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | CW | Channel being set up |
| cfg_base | input | AW | New base address |
| cfg_limit | input | AW | New limit address |
| push_req | input | 1 | Push request |
| push_ch | input | CW | Push channel |
| push_data | input | DW | Word to push |
| push_ack | output | 1 | Push accepted this cycle |
| pop_req | input | 1 | Pop request |
| pop_ch | input | CW | Pop channel |
| pop_ack | output | 1 | Pop accepted this cycle |
| pop_data | output | DW | Popped word |
| pop_dvalid | output | 1 | pop_data valid |
| empty | output | NCH | Per-channel empty flags |
| full | output | NCH | Per-channel full flags |
| peek_we | input | 1 | Peek control write strobe |
| peek_en_in | input | 1 | Peek enable value |
| peek_ch_in | input | CW | Peek channel value |
| peek_addr_in | input | AW | Peek RAM address value |
| peek_rd_ptr | output | AW | Selected channel read pointer, 0 when off |
| peek_wr_ptr | output | AW | Selected channel write pointer, 0 when off |
| peek_data | output | DW | Peeked RAM word |
| peek_valid | output | 1 | peek_data valid |

## Verification
Two pairs of functions can land in the same cycle. First, an accepted pop and a pending peek both want the single read port. The bench provokes this by raising pop_req while peeking is enabled. It then checks that the popped word arrives with pop_dvalid while peek_valid drops for exactly that cycle, and that the peeked word returns one cycle later. Second, a setup write and a push can target the same channel. The bench checks that push_ack stays low, and uses the peek pointers to confirm that both pointers landed on the new base.

// File: rtl/cfq_pkg.sv
// Shared types for the circular command queue.
// Assumes nothing beyond a single clock domain.
package cfq_pkg;
    // Owner of the RAM read port in a given cycle
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_POP  = 2'd1,
        RD_PEEK = 2'd2
    } rd_owner_e;
endpackage

// File: rtl/cfq_ram.sv
// Simple word RAM: one write port and one registered read port.
// Assumes a read of an address being written returns the old word.
module cfq_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store pushed words
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read for pops and peeks
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cfq_chan_ptrs.sv
// Pointer pair and region bounds of one channel.
// Assumes base <= limit and that push/pop are only asserted when allowed.
module cfq_chan_ptrs #(
    parameter int            AW        = 6,
    parameter logic [AW-1:0] RST_BASE  = '0,
    parameter logic [AW-1:0] RST_LIMIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_go,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic          push_go,
    input  logic          pop_go,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output logic          empty,
    output logic          full
);
    logic [AW-1:0] base_q, limit_q, wr_nxt, rd_nxt;

    // Next position with wrap from limit back to base
    always_comb begin
        wr_nxt = (wr_ptr == limit_q) ? base_q : wr_ptr + 1'b1;
        rd_nxt = (rd_ptr == limit_q) ? base_q : rd_ptr + 1'b1;
    end

    // Status flags from the pointer pair
    always_comb begin
        empty = (rd_ptr == wr_ptr);
        full  = (wr_nxt == rd_ptr);
    end

    // Bounds and pointers; a setup write restarts the queue at its base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= RST_BASE;
            limit_q <= RST_LIMIT;
            rd_ptr  <= RST_BASE;
            wr_ptr  <= RST_BASE;
        end else if (cfg_go) begin
            base_q  <= cfg_base;
            limit_q <= cfg_limit;
            rd_ptr  <= cfg_base;
            wr_ptr  <= cfg_base;
        end else begin
            if (push_go) wr_ptr <= wr_nxt;
            if (pop_go)  rd_ptr <= rd_nxt;
        end
    end
endmodule

// File: rtl/cfq_cmd_fifo.sv
// Multi-channel circular command queue in a shared RAM with a debug peek port.
// Assumes NCH is a power of two and every region lies inside the RAM.
// Pushes own the write port; on the read port a pop beats a peek.
module cfq_cmd_fifo
    import cfq_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 6,
    parameter int DW  = 32,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CW-1:0]  cfg_ch,
    input  logic [AW-1:0]  cfg_base,
    input  logic [AW-1:0]  cfg_limit,
    input  logic           push_req,
    input  logic [CW-1:0]  push_ch,
    input  logic [DW-1:0]  push_data,
    output logic           push_ack,
    input  logic           pop_req,
    input  logic [CW-1:0]  pop_ch,
    output logic           pop_ack,
    output logic [DW-1:0]  pop_data,
    output logic           pop_dvalid,
    output logic [NCH-1:0] empty,
    output logic [NCH-1:0] full,
    input  logic           peek_we,
    input  logic           peek_en_in,
    input  logic [CW-1:0]  peek_ch_in,
    input  logic [AW-1:0]  peek_addr_in,
    output logic [AW-1:0]  peek_rd_ptr,
    output logic [AW-1:0]  peek_wr_ptr,
    output logic [DW-1:0]  peek_data,
    output logic           peek_valid
);
    localparam int DEPTH = 1 << AW;
    localparam int SLICE = DEPTH / NCH;

    logic [AW-1:0] rd_ptr [NCH];
    logic [AW-1:0] wr_ptr [NCH];
    logic          peek_en_q;
    logic [CW-1:0] peek_ch_q;
    logic [AW-1:0] peek_addr_q;
    logic          rd_re;
    logic [AW-1:0] rd_addr;
    rd_owner_e     rd_own_d, rd_own_q;
    logic [DW-1:0] rd_word;

    // Accept a push or pop unless blocked by status or a setup write on that channel
    always_comb begin
        push_ack = push_req && !full[push_ch] && !(cfg_we && cfg_ch == push_ch);
        pop_ack  = pop_req && !empty[pop_ch] && !(cfg_we && cfg_ch == pop_ch);
    end

    // One pointer block per channel, each reset to an equal slice
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] B = AW'(i * SLICE);
        localparam logic [AW-1:0] L = AW'(i * SLICE + SLICE - 1);
        cfq_chan_ptrs #(.AW(AW), .RST_BASE(B), .RST_LIMIT(L)) ptrs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_go    (cfg_we && cfg_ch == CW'(i)),
            .cfg_base  (cfg_base),
            .cfg_limit (cfg_limit),
            .push_go   (push_ack && push_ch == CW'(i)),
            .pop_go    (pop_ack && pop_ch == CW'(i)),
            .rd_ptr    (rd_ptr[i]),
            .wr_ptr    (wr_ptr[i]),
            .empty     (empty[i]),
            .full      (full[i])
        );
    end

    // Peek control register; a write with enable 0 turns peeking off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peek_en_q   <= 1'b0;
            peek_ch_q   <= '0;
            peek_addr_q <= '0;
        end else if (peek_we) begin
            peek_en_q   <= peek_en_in;
            peek_ch_q   <= peek_ch_in;
            peek_addr_q <= peek_addr_in;
        end
    end

    // Read port arbitration: pop first, then peek
    always_comb begin
        rd_re    = 1'b0;
        rd_addr  = '0;
        rd_own_d = RD_IDLE;
        if (pop_ack) begin
            rd_re    = 1'b1;
            rd_addr  = rd_ptr[pop_ch];
            rd_own_d = RD_POP;
        end else if (peek_en_q && !peek_we) begin
            rd_re    = 1'b1;
            rd_addr  = peek_addr_q;
            rd_own_d = RD_PEEK;
        end
    end

    // Remember who owns the word arriving next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rd_own_q <= RD_IDLE;
        else        rd_own_q <= rd_own_d;
    end

    cfq_ram #(.AW(AW), .DW(DW)) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_ack),
        .waddr (wr_ptr[push_ch]),
        .wdata (push_data),
        .re    (rd_re),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    // Drive read results and the selected channel's pointers
    always_comb begin
        pop_data    = rd_word;
        peek_data   = rd_word;
        pop_dvalid  = (rd_own_q == RD_POP);
        peek_valid  = (rd_own_q == RD_PEEK);
        peek_rd_ptr = peek_en_q ? rd_ptr[peek_ch_q] : '0;
        peek_wr_ptr = peek_en_q ? wr_ptr[peek_ch_q] : '0;
    end
endmodule

// File: rtl/cfq_cmd_fifo_chk.sv
// Property checker for cfq_cmd_fifo, attached by bind.
// Assumes the top's port names.
module cfq_cmd_fifo_chk #(
    parameter int NCH = 2,
    parameter int AW  = 6,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [CW-1:0]  cfg_ch,
    input logic           push_req,
    input logic [CW-1:0]  push_ch,
    input logic           push_ack,
    input logic [CW-1:0]  pop_ch,
    input logic           pop_ack,
    input logic           pop_dvalid,
    input logic           peek_we,
    input logic           peek_valid,
    input logic [AW-1:0]  peek_rd_ptr,
    input logic [AW-1:0]  peek_wr_ptr,
    input logic [NCH-1:0] empty,
    input logic [NCH-1:0] full
);
    // R5
    push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ack |-> !full[push_ch]);

    // R4
    pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |-> !empty[pop_ch]);

    // R6
    pop_data_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |=> pop_dvalid);

    // R6
    valid_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_dvalid && peek_valid));

    // R10
    pop_beats_peek_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |=> !peek_valid);

    // R10
    peek_ptrs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ack && !pop_ack && !cfg_we && !peek_we)
        |=> ($stable(peek_rd_ptr) && $stable(peek_wr_ptr)));

    // R7
    cfg_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && push_req && cfg_ch == push_ch) |-> !push_ack);
endmodule

bind cfq_cmd_fifo cfq_cmd_fifo_chk #(.NCH(NCH), .AW(AW)) chk_i (.*);

// File: tb/cfq_cmd_fifo_tb_top.sv
// Bench: a table of push/pop vectors, then directed peek, collision and setup tests.
module cfq_cmd_fifo_tb_top;
    localparam int NCH = 2;
    localparam int AW  = 6;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_ch = '0;
    logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
    logic          push_req = 1'b0;
    logic [0:0]    push_ch = '0;
    logic [DW-1:0] push_data = '0;
    logic          push_ack;
    logic          pop_req = 1'b0;
    logic [0:0]    pop_ch = '0;
    logic          pop_ack;
    logic [DW-1:0] pop_data;
    logic          pop_dvalid;
    logic [NCH-1:0] empty, full;
    logic          peek_we = 1'b0, peek_en_in = 1'b0;
    logic [0:0]    peek_ch_in = '0;
    logic [AW-1:0] peek_addr_in = '0;
    logic [AW-1:0] peek_rd_ptr, peek_wr_ptr;
    logic [DW-1:0] peek_data;
    logic          peek_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfq_cmd_fifo #(.NCH(NCH), .AW(AW), .DW(DW)) dut_i (.*);

    typedef struct packed {
        logic        is_pop;
        logic        ch;
        logic [31:0] data;
        logic        ack;
        logic [31:0] exp;
    } vec_t;

    // Channel 1 is first set to base 40, limit 43 (three words)
    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b1, 32'hA1, 1'b1, 32'h0},   // R2 push
        '{1'b0, 1'b1, 32'hB2, 1'b1, 32'h0},   // R2
        '{1'b0, 1'b1, 32'hC3, 1'b1, 32'h0},   // R2
        '{1'b0, 1'b1, 32'hD4, 1'b0, 32'h0},   // R5 full, refused
        '{1'b1, 1'b1, 32'h0,  1'b1, 32'hA1},  // R2 pop order
        '{1'b0, 1'b1, 32'hD4, 1'b1, 32'h0},   // R3 write pointer wraps
        '{1'b0, 1'b0, 32'hE5, 1'b1, 32'h0},   // R11 other channel
        '{1'b1, 1'b1, 32'h0,  1'b1, 32'hB2},
        '{1'b1, 1'b1, 32'h0,  1'b1, 32'hC3},
        '{1'b1, 1'b1, 32'h0,  1'b1, 32'hD4},  // R3 read pointer wraps
        '{1'b1, 1'b1, 32'h0,  1'b0, 32'h0},   // R4 empty, refused
        '{1'b1, 1'b0, 32'h0,  1'b1, 32'hE5}   // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input vec_t v);
        @(negedge clk);
        if (v.is_pop) begin pop_req = 1'b1; pop_ch = v.ch; end
        else begin push_req = 1'b1; push_ch = v.ch; push_data = v.data; end
        #1;
        check(v.is_pop ? "R4 pop_ack" : "R5 push_ack",
              32'(v.is_pop ? pop_ack : push_ack), 32'(v.ack));
        @(negedge clk);
        pop_req = 1'b0; push_req = 1'b0;
        if (v.is_pop && v.ack) begin
            check("R6 pop_dvalid", 32'(pop_dvalid), 32'h1);
            check("R2 pop_data", pop_data, v.exp);
        end
    endtask

    task automatic peek_write(input logic en, input logic ch, input logic [AW-1:0] a);
        @(negedge clk);
        peek_we = 1'b1; peek_en_in = en; peek_ch_in = ch; peek_addr_in = a;
        @(negedge clk);
        peek_we = 1'b0;
    endtask

    task automatic setup(input logic ch, input logic [AW-1:0] b, input logic [AW-1:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push1(input logic ch, input logic [31:0] d);
        @(negedge clk);
        push_req = 1'b1; push_ch = ch; push_data = d;
        @(negedge clk);
        push_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", 32'(empty), 32'h3);
        check("R1 full", 32'(full), 32'h0);
        check("R1 valids", 32'({pop_dvalid, peek_valid}), 32'h0);
        check("R1 peek ptrs", 32'({peek_rd_ptr, peek_wr_ptr}), 32'h0);
        peek_write(1'b1, 1'b1, 6'd0);
        check("R1 ch1 reset base", 32'(peek_rd_ptr), 32'd32);
        peek_write(1'b0, 1'b0, 6'd0);

        // R7 reprogram channel 1 to a three-word region
        setup(1'b1, 6'd40, 6'd43);
        peek_write(1'b1, 1'b1, 6'd0);
        check("R7 ptrs at new base", 32'({peek_rd_ptr, peek_wr_ptr}), 32'({6'd40, 6'd40}));
        peek_write(1'b0, 1'b0, 6'd0);

        for (int i = 0; i < 12; i++) begin
            do_op(VEC[i]);
            if (i == 2) check("R5 full flag", 32'(full[1]), 32'h1);
        end

        // R9 peek after two pushes at 40 and 41
        push1(1'b1, 32'h11);
        push1(1'b1, 32'h22);
        check("R4 not empty", 32'(empty[1]), 32'h0);
        peek_write(1'b1, 1'b1, 6'd41);
        @(negedge clk);
        check("R8 peek rd ptr", 32'(peek_rd_ptr), 32'd40);
        check("R8 peek wr ptr", 32'(peek_wr_ptr), 32'd42);
        check("R9 peek_valid", 32'(peek_valid), 32'h1);
        check("R9 peek_data", peek_data, 32'h22);

        // R10 pop and peek in the same cycle
        pop_req = 1'b1; pop_ch = 1'b1;
        #1 check("R10 pop_ack", 32'(pop_ack), 32'h1);
        @(negedge clk);
        pop_req = 1'b0;
        check("R10 pop wins", 32'({pop_dvalid, peek_valid}), 32'h2);
        check("R10 pop word", pop_data, 32'h11);
        @(negedge clk);
        check("R10 peek resumes", 32'(peek_valid), 32'h1);
        check("R10 peek word", peek_data, 32'h22);
        repeat (4) @(negedge clk);
        check("R10 ptrs unmoved", 32'({peek_rd_ptr, peek_wr_ptr}), 32'({6'd41, 6'd42}));

        // R8 disable
        peek_write(1'b0, 1'b1, 6'd41);
        check("R8 off ptrs", 32'({peek_rd_ptr, peek_wr_ptr}), 32'h0);
        check("R8 off valid", 32'(peek_valid), 32'h0);

        // R7 setup write collides with push to the same channel
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 1'b1; cfg_base = 6'd50; cfg_limit = 6'd55;
        push_req = 1'b1; push_ch = 1'b1; push_data = 32'h99;
        #1 check("R7 push refused", 32'(push_ack), 32'h0);
        @(negedge clk);
        cfg_we = 1'b0; push_req = 1'b0;
        check("R7 empty after setup", 32'(empty[1]), 32'h1);
        peek_write(1'b1, 1'b1, 6'd0);
        check("R7 ptrs at base", 32'({peek_rd_ptr, peek_wr_ptr}), 32'({6'd50, 6'd50}));
        check("R11 ch0 untouched", 32'(empty[0]), 32'h1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule